// File: doc/BRIEF.md
# Memory Alignment Fault Checker

This unit sits beside the load/store path and decides, for every memory reference, whether an alignment fault must be raised. Each request carries the low address bits, an encoded access width, the privilege level of the running code, and a marker for references that the hardware performs at supervisor level on the program's behalf, such as fetching a descriptor table entry. Checking is controlled by two enables: a bit in the flags register and a mask bit in a control register. A fault is only possible when both are set.

A fault is raised only for an explicit reference made at the least privileged level whose address is not a multiple of its width. The result is registered. The fault appears as a one-cycle pulse in the cycle after the request, and the faulting address is held beside it until the next fault. Delivering the fault to a handler and translating the address are left to the surrounding pipeline.

Top module: `align_chk`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `fault_o` is 0 and `fault_addr_o` is 0.
- R2: No fault is raised unless both `flag_ac_i` and `ctl_am_i` were 1 with the request. If either one is 0, the reference never faults.
- R3: A fault is raised only when `req_priv_i` equals 3, the least privileged level. Levels 0, 1 and 2 never fault.
- R4: A request with `req_implicit_i` = 1 never faults, even when it is issued at level 3.
- R5: Size code 0 (one byte) never faults, whatever the address.
- R6: Size code 1 (two bytes) faults when address bit 0 is 1.
- R7: Size code 2 (four bytes) faults when address bits 1:0 are not both zero.
- R8: Size code 3 (eight bytes) faults when address bits 2:0 are not all zero.
- R9: `fault_o` is 1 exactly in the cycle after an edge at which `req_valid_i` = 1 and the conditions of R2 to R8 call for a fault. It is 0 in every other cycle, so it forms a one-cycle pulse for each such request.
- R10: In the cycle when `fault_o` is 1, `fault_addr_o` shows the full address of the faulting request. In all other cycles it holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | A memory reference is presented this cycle |
| req_addr_i | input | ADDR_W | Address of the reference |
| req_size_i | input | 2 | Width code: 0=1 B, 1=2 B, 2=4 B, 3=8 B |
| req_priv_i | input | 2 | Privilege level of the running code (3 = user) |
| req_implicit_i | input | 1 | The reference is implicitly made at supervisor level |
| flag_ac_i | input | 1 | Alignment-check bit of the flags register |
| ctl_am_i | input | 1 | Alignment-mask bit of the control register |
| fault_o | output | 1 | One-cycle alignment fault pulse |
| fault_addr_o | output | ADDR_W | Address of the most recent faulting reference |

## Verification
On every cycle the assertions check that a fault pulse can be traced back to a valid request from the previous cycle. That request must have had both enables set, user privilege, no implicit marker, a multi-byte width and misaligned address bits. Every such request must produce a pulse, and the address output must change only when a pulse occurs. The bench's scenarios are needed to show the other side of the contract. A pulse lasts only one cycle when requests stop, and a held address survives a run of non-faulting traffic. Seeded random traffic covers the width and offset combinations at many privilege levels and enable settings. Directed cases cover each alignment boundary.

// File: rtl/align_pkg.sv
package align_pkg;

    // Encoded access width; the code equals log2 of the byte count.
    typedef enum logic [1:0] {
        ACC_B1 = 2'd0,
        ACC_B2 = 2'd1,
        ACC_B4 = 2'd2,
        ACC_B8 = 2'd3
    } acc_size_e;

    localparam int unsigned SIZE_W   = 2;
    localparam int unsigned PRIV_W   = 2;
    localparam int unsigned MAX_LG2  = 3;   // widest access is 2**MAX_LG2 bytes
    localparam logic [PRIV_W-1:0] USER_PRIV = 2'd3;

endpackage

// File: rtl/align_mask_dec.sv
// Turns the width code into the mask of address bits that must be zero.
module align_mask_dec
    import align_pkg::*;
#(
    parameter int unsigned OFS_W = MAX_LG2
) (
    input  logic [SIZE_W-1:0] size_i,
    output logic [OFS_W-1:0]  mask_o
);

    for (genvar b = 0; b < OFS_W; b++) begin : g_bit
        // Bit b must be clear for any access wider than 2**b bytes.
        assign mask_o[b] = (int'(size_i) > b);
    end

endmodule

// File: rtl/align_enable.sv
// Decides whether the current reference is subject to checking at all.
module align_enable
    import align_pkg::*;
(
    input  logic              flag_ac_i,
    input  logic              ctl_am_i,
    input  logic [PRIV_W-1:0] priv_i,
    input  logic              implicit_i,
    output logic              en_o
);

    logic both_on;
    logic user_lvl;

    always_comb begin
        both_on  = flag_ac_i & ctl_am_i;
        user_lvl = (priv_i == USER_PRIV);
        en_o     = both_on & user_lvl & ~implicit_i;
    end

endmodule

// File: rtl/align_chk.sv
module align_chk
    import align_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_valid_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [1:0]        req_size_i,
    input  logic [1:0]        req_priv_i,
    input  logic              req_implicit_i,
    input  logic              flag_ac_i,
    input  logic              ctl_am_i,
    output logic              fault_o,
    output logic [ADDR_W-1:0] fault_addr_o
);

    localparam int unsigned OFS_W = MAX_LG2;

    typedef struct packed {
        logic              fault;
        logic [ADDR_W-1:0] addr;
    } chk_state_t;

    chk_state_t state_d, state_q;

    logic [OFS_W-1:0] mask;
    logic             chk_en;
    logic             misal;

    align_mask_dec #(.OFS_W(OFS_W)) i_mask_dec (
        .size_i (req_size_i),
        .mask_o (mask)
    );

    align_enable i_enable (
        .flag_ac_i  (flag_ac_i),
        .ctl_am_i   (ctl_am_i),
        .priv_i     (req_priv_i),
        .implicit_i (req_implicit_i),
        .en_o       (chk_en)
    );

    always_comb begin
        misal         = |(req_addr_i[OFS_W-1:0] & mask);
        state_d       = state_q;
        state_d.fault = req_valid_i & chk_en & misal;
        if (state_d.fault) begin
            state_d.addr = req_addr_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign fault_o      = state_q.fault;
    assign fault_addr_o = state_q.addr;

endmodule

// File: rtl/align_chk_sva.sv
module align_chk_sva #(
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              req_valid_i,
    input logic [ADDR_W-1:0] req_addr_i,
    input logic [1:0]        req_size_i,
    input logic [1:0]        req_priv_i,
    input logic              req_implicit_i,
    input logic              flag_ac_i,
    input logic              ctl_am_i,
    input logic              fault_o,
    input logic [ADDR_W-1:0] fault_addr_o
);

    logic [2:0] ref_mask;
    logic       ref_bad;
    logic       ref_hit;

    always_comb begin
        case (req_size_i)
            2'd0:    ref_mask = 3'b000;
            2'd1:    ref_mask = 3'b001;
            2'd2:    ref_mask = 3'b011;
            default: ref_mask = 3'b111;
        endcase
        ref_bad = (req_addr_i[2:0] & ref_mask) != 3'b000;
        ref_hit = req_valid_i && flag_ac_i && ctl_am_i && (req_priv_i == 2'd3)
                  && !req_implicit_i && ref_bad;
    end

    // R9
    pulse_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_o |-> $past(req_valid_i));

    // R2
    both_enables_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_o |-> $past(flag_ac_i && ctl_am_i));

    // R3
    user_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_o |-> ($past(req_priv_i) == 2'd3));

    // R4
    implicit_exempt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_o |-> !$past(req_implicit_i));

    // R5
    byte_never_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_o |-> ($past(req_size_i) != 2'd0));

    // R6 R7 R8
    misaligned_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_o |-> $past(ref_bad));

    // R9
    hit_raises_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ref_hit |=> fault_o);

    // R10
    addr_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_o |-> (fault_addr_o == $past(req_addr_i)));

    // R10
    addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !fault_o |-> $stable(fault_addr_o));

endmodule

bind align_chk align_chk_sva #(.ADDR_W(ADDR_W)) i_align_chk_sva (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .req_valid_i    (req_valid_i),
    .req_addr_i     (req_addr_i),
    .req_size_i     (req_size_i),
    .req_priv_i     (req_priv_i),
    .req_implicit_i (req_implicit_i),
    .flag_ac_i      (flag_ac_i),
    .ctl_am_i       (ctl_am_i),
    .fault_o        (fault_o),
    .fault_addr_o   (fault_addr_o)
);

// File: tb/test_align_chk.sv
module test_align_chk;

    localparam int unsigned ADDR_W = 32;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              valid;
    logic [ADDR_W-1:0] addr;
    logic [1:0]        size;
    logic [1:0]        priv;
    logic              impl;
    logic              ac;
    logic              am;
    logic              fault;
    logic [ADDR_W-1:0] faddr;

    int checks   = 0;
    int failures = 0;
    logic [ADDR_W-1:0] exp_addr = '0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    align_chk #(.ADDR_W(ADDR_W)) i_align_chk (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .req_valid_i    (valid),
        .req_addr_i     (addr),
        .req_size_i     (size),
        .req_priv_i     (priv),
        .req_implicit_i (impl),
        .flag_ac_i      (ac),
        .ctl_am_i       (am),
        .fault_o        (fault),
        .fault_addr_o   (faddr)
    );

    function automatic bit model_fault(bit v, logic [ADDR_W-1:0] a, logic [1:0] s,
                                       logic [1:0] p, bit im, bit f_ac, bit f_am);
        logic [2:0] m;
        m = (s == 2'd0) ? 3'b000 : (s == 2'd1) ? 3'b001 : (s == 2'd2) ? 3'b011 : 3'b111;
        return v && f_ac && f_am && (p == 2'd3) && !im && ((a[2:0] & m) != 3'b000);
    endfunction

    task automatic check(string tag, logic [ADDR_W-1:0] act, logic [ADDR_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive at a falling edge, let one rising edge register it, check at the next falling edge.
    task automatic step(string tag, bit v, logic [ADDR_W-1:0] a, logic [1:0] s,
                        logic [1:0] p, bit im, bit f_ac, bit f_am);
        bit ef;
        valid = v; addr = a; size = s; priv = p; impl = im; ac = f_ac; am = f_am;
        ef = model_fault(v, a, s, p, im, f_ac, f_am);
        if (ef) exp_addr = a;
        @(posedge clk);
        @(negedge clk);
        check({tag, " fault"}, ADDR_W'(fault), ADDR_W'(ef));
        check({tag, " addr"}, faddr, exp_addr);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; valid = 0; addr = '0; size = 0; priv = 0; impl = 0; ac = 0; am = 0;
        repeat (3) @(negedge clk);
        // R1 during reset (inputs set to a faulting request)
        valid = 1; addr = 32'h13; size = 2'd2; priv = 2'd3; ac = 1; am = 1;
        @(posedge clk); @(negedge clk);
        check("R1 reset fault", ADDR_W'(fault), '0);
        check("R1 reset addr", faddr, '0);
        valid = 0;
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R1 after reset fault", ADDR_W'(fault), '0);
        check("R1 after reset addr", faddr, '0);

        step("R6 2B odd",        1, 32'h1001, 2'd1, 2'd3, 0, 1, 1);
        step("R9 pulse ends",    0, 32'h1001, 2'd1, 2'd3, 0, 1, 1);
        step("R6 2B even",       1, 32'h2002, 2'd1, 2'd3, 0, 1, 1);
        step("R5 1B odd",        1, 32'h3007, 2'd0, 2'd3, 0, 1, 1);
        step("R7 4B off2",       1, 32'h4002, 2'd2, 2'd3, 0, 1, 1);
        step("R7 4B aligned",    1, 32'h4004, 2'd2, 2'd3, 0, 1, 1);
        step("R8 8B off4",       1, 32'h5004, 2'd3, 2'd3, 0, 1, 1);
        step("R8 8B aligned",    1, 32'h5008, 2'd3, 2'd3, 0, 1, 1);
        step("R2 ac clear",      1, 32'h6003, 2'd2, 2'd3, 0, 0, 1);
        step("R2 am clear",      1, 32'h6005, 2'd2, 2'd3, 0, 1, 0);
        step("R3 level0",        1, 32'h7001, 2'd1, 2'd0, 0, 1, 1);
        step("R3 level2",        1, 32'h7003, 2'd3, 2'd2, 0, 1, 1);
        step("R4 implicit",      1, 32'h8006, 2'd3, 2'd3, 1, 1, 1);
        step("R9 no valid",      0, 32'h9001, 2'd1, 2'd3, 0, 1, 1);
        step("R10 capture",      1, 32'hA5A5_0003, 2'd2, 2'd3, 0, 1, 1);
        step("R10 hold",         1, 32'hFFFF_0000, 2'd3, 2'd3, 0, 1, 1);
        step("R9 back to back a", 1, 32'hB001, 2'd1, 2'd3, 0, 1, 1);
        step("R9 back to back b", 1, 32'hB003, 2'd2, 2'd3, 0, 1, 1);

        for (int i = 0; i < 3000; i++) begin
            bit v, im, fa, fm;
            logic [1:0] p;
            v  = ($urandom % 4) != 0;
            im = ($urandom % 5) == 0;
            fa = ($urandom % 6) != 0;
            fm = ($urandom % 6) != 0;
            p  = (($urandom % 3) == 0) ? 2'($urandom) : 2'd3;
            step("R9 R10 random", v, ADDR_W'($urandom), 2'($urandom), p, im, fa, fm);
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule